// File: doc/BRIEF.md
# Grouped Serial Audio Output Port

This block turns parallel audio sample words into serial bit streams on eight data pins. The pins form two groups of four. Each group has its own bit clock and frame pulse, its own format, word length and slot layout. Each clock pair is either a master, generated from the system clock, or a slave, taken from outside and sampled on the system clock. Each group reads sixteen 24-bit words from a parallel sample bus. It captures those words, together with its settings, at every frame boundary.

In pair mode, every pin of a group carries two 32-bit slots in a 64-bit frame. In one-wire-per-group TDM mode, the first pin of each group carries eight slots in a 256-bit frame, and the other three pins stay low. Group 0 can also run a wide TDM mode that places all sixteen of its words on pin 0 in a 512-bit frame. Within a slot, a word can be aligned in three ways: one bit late after the frame edge, on the edge, or ending at the last bit of the slot. The word is sent MSB first.

Top module: `grouped_serial_out`

## Requirements
- R1: Pins 0-3 are timed only by clock pair 0 and use the group 0 settings; pins 4-7 are timed only by pair 1 and use the group 1 settings; a change to one group's settings or clock role leaves the other group's output unchanged.
- R2: `clk_oe_o[g]` equals `master_i[g]` one system clock later. During reset and after it, `clk_oe_o` is 0 and the pairs are slaves. While a pair is a slave, its `bclk_o` and `fs_o` are held at 0. In slave mode a new bit starts at each falling edge of `bclk_i`, and a frame starts at a falling edge where `fs_i` is high.
- R3: Mode code 0 is pair mode. Pin k of a group sends word 2k in bits 0-31 and word 2k+1 in bits 32-63 of a 64-bit frame.
- R4: Format code 0 puts word bit j at slot bit j+1. Code 1 puts it at slot bit j. Code 2 puts the last word bit at slot bit 31. Code 3 behaves as code 1.
- R5: Word-length code 0 sends 16 bits, code 1 sends 20 bits, and codes 2 and 3 send 24 bits. The bits sent are the top bits of the 24-bit word, MSB first. Slot bits that carry no word bit are 0.
- R6: Mode code 1 sends words 0-7 of the group in eight 32-bit slots of a 256-bit frame. They go on pin 0 for group 0 and on pin 4 for group 1. The other three pins of the group are 0.
- R7: Mode codes 2 and 3 on group 0 send words 0-15 on pin 0 in a 512-bit frame. On group 1, these codes behave as mode code 1.
- R8: In master mode, `bclk_o` has a period of BCLK_DIV system clocks. Data and `fs_o` change only when `bclk_o` falls. `fs_o` is high exactly during bit 0 of each frame.
- R9: The sample words and the format, length and mode settings are captured at the start of each frame. Changes during a frame take effect only from the next frame.
- R10: During reset and directly after it, all eight data pins are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 2 | Clock role per pair, 1 = master |
| bclk_i | input | 2 | External bit clock per pair (slave) |
| fs_i | input | 2 | External frame pulse per pair (slave) |
| fmt_i | input | 4 | Alignment code, bits [2g+1:2g] for group g |
| wlen_i | input | 4 | Word-length code per group |
| mode_i | input | 4 | Slot layout code per group |
| samples_i | input | 2*16*WORD_W | Word w of group g at bits [(16g+w)*WORD_W +: WORD_W] |
| bclk_o | output | 2 | Generated bit clock per pair |
| fs_o | output | 2 | Generated frame pulse per pair |
| clk_oe_o | output | 2 | Drive enable for the pair's clock pins |
| sd_o | output | 8 | Serial data pins |

## Verification
The hardest situation to reach from the ports is a change of samples and settings partway through a frame. The bench has to show that the frame in progress still carries the old words and the old alignment. To do this, it changes every word and the alignment code of a group a few bits after the frame pulse. It compares the whole frame against the old values, then the following frame against the new ones. Slave timing is reached by driving the bit clock and frame pulse of pair 0 from the bench, while pair 1 keeps running as a master beside it.

// File: rtl/gso_pkg.sv
package gso_pkg;

    localparam logic [1:0] FMT_DELAYED = 2'd0;
    localparam logic [1:0] FMT_ON_EDGE = 2'd1;
    localparam logic [1:0] FMT_TAIL    = 2'd2;

    localparam logic [1:0] LAYOUT_PAIR = 2'd0;
    localparam logic [1:0] LAYOUT_TDM8 = 2'd1;

    // Number of bits sent for a word-length code.
    function automatic int word_len(input logic [1:0] code);
        int n;
        case (code)
            2'd0:    n = 16;
            2'd1:    n = 20;
            default: n = 24;
        endcase
        return n;
    endfunction

    // Word bit (counted from the MSB) carried at slot bit pos, or -1 for an idle bit.
    function automatic int lead_bit(input logic [1:0] fmt, input int pos,
                                    input int wl, input int slot_w);
        int j;
        j = -1;
        case (fmt)
            FMT_DELAYED: if (pos >= 1 && pos <= wl) j = pos - 1;
            FMT_TAIL:    if (pos >= slot_w - wl)    j = pos - (slot_w - wl);
            default:     if (pos < wl)              j = pos;
        endcase
        return j;
    endfunction

endpackage

// File: rtl/gso_slot_map.sv
module gso_slot_map #(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32,
    parameter int WORDS  = 16,
    parameter int PINS   = 4,
    parameter bit WIDE   = 1'b1,
    parameter int CNT_W  = 9
) (
    input  logic [CNT_W-1:0]                cnt_i,
    input  logic [1:0]                      mode_i,
    input  logic [1:0]                      fmt_i,
    input  logic [1:0]                      wlen_i,
    input  logic [WORDS-1:0][WORD_W-1:0]    words_i,
    output logic [PINS-1:0]                 sd_o
);
    localparam int POS_W = $clog2(SLOT_W);
    localparam int WB_W  = $clog2(WORD_W);
    localparam int WIX_W = $clog2(WORDS);

    logic [POS_W-1:0]       pos;
    logic [CNT_W-POS_W-1:0] slot;
    logic [WB_W-1:0]        bsel;
    int                     j;
    int                     lim;

    assign pos  = cnt_i[POS_W-1:0];
    assign slot = cnt_i[CNT_W-1:POS_W];

    always_comb begin
        sd_o = '0;
        j    = gso_pkg::lead_bit(fmt_i, int'(pos), gso_pkg::word_len(wlen_i), SLOT_W);
        bsel = WB_W'(WORD_W - 1 - ((j < 0) ? 0 : j));
        lim  = (WIDE && mode_i[1]) ? WORDS : WORDS / 2;
        if (j >= 0) begin
            if (mode_i == gso_pkg::LAYOUT_PAIR) begin
                for (int k = 0; k < PINS; k++) begin
                    if (int'(slot) < 2)
                        sd_o[k] = words_i[WIX_W'(2 * k + int'(slot))][bsel];
                end
            end else if (int'(slot) < lim) begin
                sd_o[0] = words_i[WIX_W'(slot)][bsel];
            end
        end
    end

endmodule

// File: rtl/gso_group.sv
module gso_group #(
    parameter int WORD_W   = 24,
    parameter int SLOT_W   = 32,
    parameter int WORDS    = 16,
    parameter int PINS     = 4,
    parameter bit WIDE     = 1'b1,
    parameter int BCLK_DIV = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     master_i,
    input  logic                     bclk_i,
    input  logic                     fs_i,
    input  logic [1:0]               fmt_i,
    input  logic [1:0]               wlen_i,
    input  logic [1:0]               mode_i,
    input  logic [WORDS*WORD_W-1:0]  words_i,
    output logic                     bclk_o,
    output logic                     fs_o,
    output logic                     oe_o,
    output logic [PINS-1:0]          sd_o
);
    localparam int CNT_W     = $clog2(WORDS * SLOT_W);
    localparam int PH_W      = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
    localparam int LAST_PAIR = 2 * SLOT_W - 1;
    localparam int LAST_T8   = (WORDS / 2) * SLOT_W - 1;
    localparam int LAST_WIDE = WIDE ? WORDS * SLOT_W - 1 : LAST_T8;

    typedef struct packed {
        logic                           master;
        logic [PH_W-1:0]                phase;
        logic                           bclk;
        logic [2:0]                     bsync;
        logic [1:0]                     fsync;
        logic [CNT_W-1:0]               cnt;
        logic [1:0]                     mode;
        logic [1:0]                     fmt;
        logic [1:0]                     wlen;
        logic [WORDS-1:0][WORD_W-1:0]   words;
    } grp_state_t;

    grp_state_t       st_q, st_d;
    logic             tick;
    logic             start;
    logic [CNT_W-1:0] last;

    always_comb begin
        st_d       = st_q;
        st_d.master = master_i;
        st_d.bsync = {st_q.bsync[1:0], bclk_i};
        st_d.fsync = {st_q.fsync[0], fs_i};
        st_d.phase = (st_q.phase == PH_W'(BCLK_DIV - 1)) ? '0 : st_q.phase + 1'b1;
        st_d.bclk  = st_d.master && (st_d.phase >= PH_W'(BCLK_DIV / 2));

        case (st_q.mode)
            gso_pkg::LAYOUT_PAIR: last = CNT_W'(LAST_PAIR);
            gso_pkg::LAYOUT_TDM8: last = CNT_W'(LAST_T8);
            default:              last = CNT_W'(LAST_WIDE);
        endcase

        tick  = st_q.master ? (st_q.phase == PH_W'(BCLK_DIV - 1))
                            : (st_q.bsync[2] && !st_q.bsync[1]);
        start = st_q.master ? (st_q.cnt >= last) : st_q.fsync[1];

        if (tick) begin
            if (start) begin
                st_d.cnt   = '0;
                st_d.mode  = mode_i;
                st_d.fmt   = fmt_i;
                st_d.wlen  = wlen_i;
                st_d.words = words_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cnt <= CNT_W'(LAST_PAIR);
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;
    assign fs_o   = st_q.master && (st_q.cnt == '0);
    assign oe_o   = st_q.master;

    gso_slot_map #(
        .WORD_W (WORD_W),
        .SLOT_W (SLOT_W),
        .WORDS  (WORDS),
        .PINS   (PINS),
        .WIDE   (WIDE),
        .CNT_W  (CNT_W)
    ) u_map (
        .cnt_i   (st_q.cnt),
        .mode_i  (st_q.mode),
        .fmt_i   (st_q.fmt),
        .wlen_i  (st_q.wlen),
        .words_i (st_q.words),
        .sd_o    (sd_o)
    );

endmodule

// File: rtl/grouped_serial_out.sv
module grouped_serial_out #(
    parameter int WORD_W       = 24,
    parameter int SLOT_W       = 32,
    parameter int CH_PER_GRP   = 16,
    parameter int PINS_PER_GRP = 4,
    parameter int BCLK_DIV     = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [1:0]                          master_i,
    input  logic [1:0]                          bclk_i,
    input  logic [1:0]                          fs_i,
    input  logic [3:0]                          fmt_i,
    input  logic [3:0]                          wlen_i,
    input  logic [3:0]                          mode_i,
    input  logic [2*CH_PER_GRP*WORD_W-1:0]      samples_i,
    output logic [1:0]                          bclk_o,
    output logic [1:0]                          fs_o,
    output logic [1:0]                          clk_oe_o,
    output logic [2*PINS_PER_GRP-1:0]           sd_o
);
    localparam int GROUPS = 2;
    localparam int GRP_W  = CH_PER_GRP * WORD_W;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        gso_group #(
            .WORD_W   (WORD_W),
            .SLOT_W   (SLOT_W),
            .WORDS    (CH_PER_GRP),
            .PINS     (PINS_PER_GRP),
            .WIDE     (g == 0),
            .BCLK_DIV (BCLK_DIV)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .master_i (master_i[g]),
            .bclk_i   (bclk_i[g]),
            .fs_i     (fs_i[g]),
            .fmt_i    (fmt_i[2*g +: 2]),
            .wlen_i   (wlen_i[2*g +: 2]),
            .mode_i   (mode_i[2*g +: 2]),
            .words_i  (samples_i[g*GRP_W +: GRP_W]),
            .bclk_o   (bclk_o[g]),
            .fs_o     (fs_o[g]),
            .oe_o     (clk_oe_o[g]),
            .sd_o     (sd_o[g*PINS_PER_GRP +: PINS_PER_GRP])
        );
    end

endmodule

// File: rtl/gso_chk.sv
module gso_chk #(
    parameter int PINS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        master_i,
    input logic [1:0]        bclk_o,
    input logic [1:0]        fs_o,
    input logic [1:0]        clk_oe_o,
    input logic [2*PINS-1:0] sd_o
);
    for (genvar g = 0; g < 2; g++) begin : g_pair
        // R2
        oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (clk_oe_o[g] == $past(master_i[g])));

        // R2
        slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clk_oe_o[g] |-> (!bclk_o[g] && !fs_o[g]));

        // R8
        fs_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_oe_o[g] && $past(clk_oe_o[g]) && !$stable(fs_o[g])) |-> $fell(bclk_o[g]));

        // R8
        data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_oe_o[g] && $past(clk_oe_o[g]) && !$stable(sd_o[g*PINS +: PINS]))
                |-> $fell(bclk_o[g]));
    end

endmodule

bind grouped_serial_out gso_chk #(.PINS(PINS_PER_GRP)) u_gso_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .master_i (master_i),
    .bclk_o   (bclk_o),
    .fs_o     (fs_o),
    .clk_oe_o (clk_oe_o),
    .sd_o     (sd_o)
);

// File: tb/grouped_serial_out_tb.sv
module grouped_serial_out_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [1:0]    master, bclk_in, fs_in;
    logic [3:0]    fmt, wlen, mode;
    logic [767:0]  samples;
    logic [1:0]    bclk_o, fs_o, clk_oe;
    logic [7:0]    sd;
    logic [23:0]   wv [2][16];
    logic [23:0]   ev [2][16];
    int            tests = 0;
    int            fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always_comb begin
        for (int g = 0; g < 2; g++)
            for (int w = 0; w < 16; w++)
                samples[(g * 16 + w) * 24 +: 24] = wv[g][w];
    end

    grouped_serial_out #(.BCLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .master_i(master), .bclk_i(bclk_in), .fs_i(fs_in),
        .fmt_i(fmt), .wlen_i(wlen), .mode_i(mode), .samples_i(samples),
        .bclk_o(bclk_o), .fs_o(fs_o), .clk_oe_o(clk_oe), .sd_o(sd)
    );

    task automatic chk(input bit ok, input string req, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [23:0] pat(input int seed, input int g, input int w);
        logic [31:0] x;
        x = 32'(seed) * 32'h41C64E6D + 32'(g * 16 + w + 1) * 32'h9E3779B9;
        x = x ^ (x >> 11);
        return x[27:4];
    endfunction

    task automatic set_words(input int seed);
        for (int g = 0; g < 2; g++)
            for (int w = 0; w < 16; w++) begin
                wv[g][w] = pat(seed, g, w);
                ev[g][w] = wv[g][w];
            end
    endtask

    function automatic int eff_mode(input int g, input int md);
        if (md == 0) return 0;
        if (md >= 2 && g == 0) return 2;
        return 1;
    endfunction

    function automatic int frame_len(input int g, input int md);
        int e;
        e = eff_mode(g, md);
        return (e == 0) ? 64 : (e == 1) ? 256 : 512;
    endfunction

    // Expected pin value from R3-R7
    function automatic logic exp_bit(input int g, input int pin, input int b,
                                     input int md, input int f, input int wl);
        int slot, pos, n, j, e, ff;
        slot = b / 32;
        pos  = b % 32;
        n    = (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
        ff   = (f == 3) ? 1 : f;
        j    = -1;
        if (ff == 0 && pos >= 1 && pos <= n) j = pos - 1;
        if (ff == 1 && pos < n)              j = pos;
        if (ff == 2 && pos >= 32 - n)        j = pos - (32 - n);
        if (j < 0) return 1'b0;
        e = eff_mode(g, md);
        if (e == 0) return (slot < 2) ? ev[g][2 * pin + slot][23 - j] : 1'b0;
        if (pin != 0) return 1'b0;
        if (slot < ((e == 2) ? 16 : 8)) return ev[g][slot][23 - j];
        return 1'b0;
    endfunction

    task automatic wait_rise(input int g);
        logic p;
        p = bclk_o[g];
        forever begin
            @(negedge clk);
            if (!p && bclk_o[g]) break;
            p = bclk_o[g];
        end
    endtask

    task automatic cap_master(input int g, input int md, input int f, input int wl,
                              input bit mid, input string req);
        int len, errs;
        string info;
        logic a, e;
        len = frame_len(g, md);
        errs = 0;
        info = "none";
        do @(negedge clk); while (fs_o[g] !== 1'b0);
        forever begin
            wait_rise(g);
            if (fs_o[g]) break;
        end
        for (int b = 0; b < len; b++) begin
            if (b > 0) wait_rise(g);
            if (fs_o[g] !== (b == 0)) begin
                if (errs == 0) info = $sformatf("fs at bit %0d act %b exp %b", b, fs_o[g], b == 0);
                errs++;
            end
            for (int p = 0; p < 4; p++) begin
                a = sd[g * 4 + p];
                e = exp_bit(g, p, b, md, f, wl);
                if (a !== e) begin
                    if (errs == 0) info = $sformatf("bit %0d pin %0d act %b exp %b", b, g * 4 + p, a, e);
                    errs++;
                end
            end
            if (mid && b == 5) begin
                for (int w = 0; w < 16; w++) wv[g][w] = pat(900 + g, g, w);
                fmt[2 * g +: 2] = 2'd2;
            end
        end
        chk(errs == 0, req, $sformatf("group %0d mode %0d fmt %0d wlen %0d: %0d mismatches, first %s",
            g, md, f, wl, errs, info));
    endtask

    task automatic cap_slave(input int md, input int f, input int wl, input string req);
        int len, errs;
        string info;
        logic a, e;
        len = frame_len(0, md);
        errs = 0;
        info = "none";
        bclk_in[0] = 1'b1;
        fs_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < len; b++) begin
            bclk_in[0] = 1'b0;
            fs_in[0] = (b == 0);
            repeat (6) @(negedge clk);
            bclk_in[0] = 1'b1;
            repeat (5) @(negedge clk);
            for (int p = 0; p < 4; p++) begin
                a = sd[p];
                e = exp_bit(0, p, b, md, f, wl);
                if (a !== e) begin
                    if (errs == 0) info = $sformatf("bit %0d pin %0d act %b exp %b", b, p, a, e);
                    errs++;
                end
            end
        end
        fs_in[0] = 1'b0;
        chk(errs == 0, req, $sformatf("slave mode %0d fmt %0d wlen %0d: %0d mismatches, first %s",
            md, f, wl, errs, info));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog: act hung exp finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        master = 2'b11;
        bclk_in = 2'b00;
        fs_in = 2'b00;
        fmt = '0;
        wlen = '0;
        mode = '0;
        set_words(1);
        repeat (5) @(negedge clk);
        // R2 R10: reset state
        chk(clk_oe === 2'b00 && bclk_o === 2'b00, "R2",
            $sformatf("in reset oe act %b exp 00", clk_oe));
        chk(sd === 8'h00, "R10", $sformatf("in reset sd act %h exp 00", sd));
        rst_n = 1'b1;
        chk(clk_oe === 2'b00 && sd === 8'h00, "R10",
            $sformatf("after reset oe act %b sd act %h exp 00/00", clk_oe, sd));
        @(negedge clk);
        chk(clk_oe === 2'b11, "R2", $sformatf("one cycle later oe act %b exp 11", clk_oe));

        // R1 R3 R4 R5 R6 R7 R8: sweep of layout, alignment and length per group
        for (int m = 0; m < 3; m++)
            for (int f = 0; f < 3; f++)
                for (int w = 0; w < 3; w++) begin
                    fmt  = {2'((f + 1) % 3), 2'(f)};
                    wlen = {2'((w + 2) % 3), 2'(w)};
                    mode = {2'(m), 2'(m)};
                    set_words(m * 9 + f * 3 + w + 2);
                    cap_master(0, m, f, w, 1'b0, m == 0 ? "R3" : m == 1 ? "R6" : "R7");
                    cap_master(1, m, (f + 1) % 3, (w + 2) % 3, 1'b0,
                               m == 2 ? "R7" : "R1");
                end

        // R4 R5: alias codes 3
        fmt = 4'b1111;
        wlen = 4'b1111;
        mode = 4'b0000;
        set_words(50);
        cap_master(0, 0, 3, 3, 1'b0, "R4");
        cap_master(1, 0, 3, 3, 1'b0, "R5");

        // R9: words and alignment changed a few bits into the frame
        fmt = 4'b0101;
        wlen = 4'b1010;
        mode = 4'b0000;
        set_words(60);
        cap_master(0, 0, 1, 2, 1'b1, "R9");
        for (int w = 0; w < 16; w++) ev[0][w] = wv[0][w];
        cap_master(0, 0, 2, 2, 1'b0, "R9");

        // R2 R1: pair 0 to slave, pair 1 stays master
        master = 2'b10;
        bclk_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(clk_oe === 2'b10, "R2", $sformatf("slave oe act %b exp 10", clk_oe));
        chk(bclk_o[0] === 1'b0 && fs_o[0] === 1'b0, "R2",
            $sformatf("slave clocks act %b%b exp 00", bclk_o[0], fs_o[0]));
        fmt = 4'b0100;
        wlen = 4'b0010;
        mode = 4'b0000;
        set_words(70);
        cap_slave(0, 0, 2, "R2");
        cap_master(1, 0, 1, 0, 1'b0, "R1");
        fmt = 4'b0010;
        wlen = 4'b0000;
        mode = 4'b0001;
        set_words(80);
        cap_slave(1, 2, 0, "R6");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule